// File: doc/BRIEF.md
# Integrate-and-Convert Row Sequencer

This block paces the readout of a resistive sensor matrix through a bank of switched integrators. Every pixel interval it holds the integrators in reset, lets them integrate for a programmed time, then holds them while a single conversion strobe samples all channels at once. All timing comes from one clock and a set of cycle counters, scaled by a parameter that gives the clock cycles per microsecond.

A frame begins with a start command. The integration time in microseconds and the number of rows to scan are clamped to their legal ranges and captured when the frame begins, so every row of the frame shares one gain. The rows are scanned in ascending order from row 0. At the start of each row's reset window the block pulses a load strobe for the compensation DAC and sends the row address over an SPI link to the analog row multiplexer. Both the DAC settling time and the SPI transfer fit inside the reset window. A frame-start pulse marks row 0 and a row-done pulse ends each row, so that downstream logic can tag the samples.

Top module: `row_scan_seq`

## Requirements
- R1: While reset is asserted and while idle, int_rst_o, integ_o, hold_o, dac_ld_o, adc_cnv_o, frame_start_o, row_done_o, busy_o, spi_sclk_o and spi_mosi_o are 0, spi_cs_n_o is 1 and row_idx_o is 0.
- R2: start_i is sampled only while idle. A start that arrives during a frame has no effect on any output.
- R3: Each pixel interval opens with a reset window of RST_US*CLK_PER_US cycles with int_rst_o high. dac_ld_o is a one-cycle pulse in the first cycle of that window.
- R4: The integrate phase (integ_o high) lasts clamp(int_us_i, MIN_INT_US, MAX_INT_US)*CLK_PER_US cycles. The value is captured when the frame starts, and later changes to int_us_i do not affect the frame in progress.
- R5: After integration, hold_o stays high for HOLD_CYC cycles. adc_cnv_o is a single pulse in the first hold cycle, once per row.
- R6: A frame scans rows 0,1,...,N-1 in ascending order, shown on row_idx_o. N is row_cnt_i clamped to 1..NUM_ROWS and captured at frame start.
- R7: The SPI write starts in the cycle after dac_ld_o. spi_cs_n_o stays low for 2*ROW_W cycles. The row address is sent MSB first, each bit held for two cycles with spi_sclk_o low and then high. The transfer ends before int_rst_o falls.
- R8: frame_start_o pulses in the first cycle of row 0. row_done_o pulses in the last hold cycle of every row.
- R9: busy_o is high from the cycle after start is accepted through the last hold cycle of the final row.
- R10: At least DAC_SETTLE_US*CLK_PER_US cycles separate dac_ld_o from the end of the same reset window.
- R11: Every row of a frame has exactly the same integrate length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start command |
| int_us_i | input | US_W | Integration time in microseconds |
| row_cnt_i | input | ROW_W+1 | Number of rows to scan |
| int_rst_o | output | 1 | Integrator reset window |
| integ_o | output | 1 | Integrate phase |
| hold_o | output | 1 | Integrator hold phase |
| dac_ld_o | output | 1 | Compensation DAC load strobe |
| adc_cnv_o | output | 1 | Simultaneous conversion strobe |
| spi_cs_n_o | output | 1 | Row mux SPI chip select, active low |
| spi_sclk_o | output | 1 | Row mux SPI clock |
| spi_mosi_o | output | 1 | Row mux SPI data |
| row_idx_o | output | ROW_W | Row being measured |
| frame_start_o | output | 1 | First cycle of row 0 |
| row_done_o | output | 1 | Last cycle of each row |
| busy_o | output | 1 | Frame in progress |

## Verification
A wrong phase counter or a wrong captured integration length changes the edge positions of int_rst_o, integ_o or hold_o within the same pixel interval, so the error shows at the ports in the first row where it occurs. A wrong row register shows up at the next reset window, both on row_idx_o and in the address bits clocked out on the SPI link. A shift register or bit counter that drifts changes spi_mosi_o or how long spi_cs_n_o stays low within a few cycles of dac_ld_o. A frame-end decision that fires early or late shows as a missing or extra row_done_o pulse and a wrong busy_o level one cycle after the final hold.

// File: rtl/row_scan_pkg.sv
package row_scan_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RST  = 2'd1,
    PH_INT  = 2'd2,
    PH_HOLD = 2'd3
  } phase_e;

  function automatic int unsigned width_of(input int unsigned max_val);
    return (max_val > 1) ? $clog2(max_val + 1) : 1;
  endfunction

endpackage

// File: rtl/row_scan_cfg.sv
module row_scan_cfg #(
  parameter int US_W       = 12,
  parameter int ROW_W      = 5,
  parameter int CNT_W      = 17,
  parameter int NUM_ROWS   = 32,
  parameter int CLK_PER_US = 50,
  parameter int MIN_INT_US = 100,
  parameter int MAX_INT_US = 2000
) (
  input  logic [US_W-1:0]  int_us_i,
  input  logic [ROW_W:0]   row_cnt_i,
  output logic [CNT_W-1:0] int_cyc_o,
  output logic [ROW_W-1:0] last_row_o
);

  localparam logic [US_W-1:0]  US_LO   = US_W'(MIN_INT_US);
  localparam logic [US_W-1:0]  US_HI   = US_W'(MAX_INT_US);
  localparam logic [ROW_W:0]   ROWS_HI = (ROW_W+1)'(NUM_ROWS);
  localparam logic [CNT_W-1:0] SCALE   = CNT_W'(CLK_PER_US);

  logic [US_W-1:0] us_clamped;
  logic [ROW_W:0]  rows_m1;

  always_comb begin
    if (int_us_i < US_LO) begin
      us_clamped = US_LO;
    end else if (int_us_i > US_HI) begin
      us_clamped = US_HI;
    end else begin
      us_clamped = int_us_i;
    end
  end

  always_comb begin
    if (row_cnt_i == '0) begin
      rows_m1 = '0;
    end else if (row_cnt_i > ROWS_HI) begin
      rows_m1 = ROWS_HI - 1'b1;
    end else begin
      rows_m1 = row_cnt_i - 1'b1;
    end
  end

  assign int_cyc_o  = CNT_W'(us_clamped) * SCALE;
  assign last_row_o = rows_m1[ROW_W-1:0];

endmodule

// File: rtl/row_scan_fsm.sv
module row_scan_fsm
  import row_scan_pkg::*;
#(
  parameter int CNT_W    = 17,
  parameter int ROW_W    = 5,
  parameter int RST_CYC  = 500,
  parameter int HOLD_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] int_cyc_i,
  input  logic [ROW_W-1:0] last_row_i,
  output logic             int_rst_o,
  output logic             integ_o,
  output logic             hold_o,
  output logic             dac_ld_o,
  output logic             adc_cnv_o,
  output logic             frame_start_o,
  output logic             row_done_o,
  output logic             busy_o,
  output logic [ROW_W-1:0] row_o
);

  localparam logic [CNT_W-1:0] RST_LAST  = CNT_W'(RST_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [CNT_W-1:0] tint_q;
  logic [ROW_W-1:0] last_q;
  logic             cfg_en;
  logic [CNT_W-1:0] int_last;

  assign int_last = tint_q - 1'b1;

  // next-state process
  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    row_d  = row_q;
    cfg_en = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d   = PH_RST;
          cnt_d  = '0;
          row_d  = '0;
          cfg_en = 1'b1;
        end
      end
      PH_RST: begin
        if (cnt_q == RST_LAST) begin
          ph_d  = PH_INT;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_INT: begin
        if (cnt_q == int_last) begin
          ph_d  = PH_HOLD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_q == HOLD_LAST) begin
          cnt_d = '0;
          if (row_q == last_q) begin
            ph_d  = PH_IDLE;
            row_d = '0;
          end else begin
            ph_d  = PH_RST;
            row_d = row_q + 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
      row_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      row_q <= row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tint_q <= '0;
      last_q <= '0;
    end else if (cfg_en) begin
      tint_q <= int_cyc_i;
      last_q <= last_row_i;
    end
  end

  assign int_rst_o     = (ph_q == PH_RST);
  assign integ_o       = (ph_q == PH_INT);
  assign hold_o        = (ph_q == PH_HOLD);
  assign dac_ld_o      = (ph_q == PH_RST) && (cnt_q == '0);
  assign adc_cnv_o     = (ph_q == PH_HOLD) && (cnt_q == '0);
  assign frame_start_o = dac_ld_o && (row_q == '0);
  assign row_done_o    = (ph_q == PH_HOLD) && (cnt_q == HOLD_LAST);
  assign busy_o        = (ph_q != PH_IDLE);
  assign row_o         = row_q;

endmodule

// File: rtl/row_scan_spi.sv
module row_scan_spi #(
  parameter int ROW_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [ROW_W-1:0] addr_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_n_o
);

  localparam int BIT_W = (ROW_W > 1) ? $clog2(ROW_W) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(ROW_W - 1);

  logic             act_q, act_d;
  logic             half_q, half_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [ROW_W-1:0] sh_q, sh_d;

  always_comb begin
    act_d  = act_q;
    half_d = half_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    if (go_i) begin
      act_d  = 1'b1;
      half_d = 1'b0;
      bit_d  = '0;
      sh_d   = addr_i;
    end else if (act_q) begin
      if (!half_q) begin
        half_d = 1'b1;
      end else begin
        half_d = 1'b0;
        sh_d   = sh_q << 1;
        bit_d  = bit_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          act_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      act_q  <= act_d;
      half_q <= half_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  assign cs_n_o = ~act_q;
  assign sclk_o = act_q & half_q;
  assign mosi_o = act_q & sh_q[ROW_W-1];

endmodule

// File: rtl/row_scan_seq.sv
module row_scan_seq #(
  parameter int CLK_PER_US    = 50,
  parameter int NUM_ROWS      = 32,
  parameter int RST_US        = 10,
  parameter int DAC_SETTLE_US = 7,
  parameter int MIN_INT_US    = 100,
  parameter int MAX_INT_US    = 2000,
  parameter int HOLD_CYC      = 4,
  parameter int US_W          = 12,
  localparam int ROW_W        = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [US_W-1:0]  int_us_i,
  input  logic [ROW_W:0]   row_cnt_i,
  output logic             int_rst_o,
  output logic             integ_o,
  output logic             hold_o,
  output logic             dac_ld_o,
  output logic             adc_cnv_o,
  output logic             spi_cs_n_o,
  output logic             spi_sclk_o,
  output logic             spi_mosi_o,
  output logic [ROW_W-1:0] row_idx_o,
  output logic             frame_start_o,
  output logic             row_done_o,
  output logic             busy_o
);

  localparam int RST_CYC = RST_US * CLK_PER_US;
  localparam int CNT_W   = row_scan_pkg::width_of(MAX_INT_US * CLK_PER_US);

  logic [CNT_W-1:0] int_cyc;
  logic [ROW_W-1:0] last_row;

  row_scan_cfg #(
    .US_W(US_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .NUM_ROWS(NUM_ROWS),
    .CLK_PER_US(CLK_PER_US), .MIN_INT_US(MIN_INT_US), .MAX_INT_US(MAX_INT_US)
  ) i_cfg (
    .int_us_i  (int_us_i),
    .row_cnt_i (row_cnt_i),
    .int_cyc_o (int_cyc),
    .last_row_o(last_row)
  );

  row_scan_fsm #(
    .CNT_W(CNT_W), .ROW_W(ROW_W), .RST_CYC(RST_CYC), .HOLD_CYC(HOLD_CYC)
  ) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .int_cyc_i    (int_cyc),
    .last_row_i   (last_row),
    .int_rst_o    (int_rst_o),
    .integ_o      (integ_o),
    .hold_o       (hold_o),
    .dac_ld_o     (dac_ld_o),
    .adc_cnv_o    (adc_cnv_o),
    .frame_start_o(frame_start_o),
    .row_done_o   (row_done_o),
    .busy_o       (busy_o),
    .row_o        (row_idx_o)
  );

  row_scan_spi #(
    .ROW_W(ROW_W)
  ) i_spi (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (dac_ld_o),
    .addr_i(row_idx_o),
    .sclk_o(spi_sclk_o),
    .mosi_o(spi_mosi_o),
    .cs_n_o(spi_cs_n_o)
  );

endmodule

// File: rtl/row_scan_seq_chk.sv
module row_scan_seq_chk #(
  parameter int CLK_PER_US    = 50,
  parameter int NUM_ROWS      = 32,
  parameter int DAC_SETTLE_US = 7,
  parameter int MIN_INT_US    = 100,
  parameter int MAX_INT_US    = 2000,
  localparam int ROW_W        = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_rst_o,
  input logic             integ_o,
  input logic             hold_o,
  input logic             dac_ld_o,
  input logic             adc_cnv_o,
  input logic             spi_cs_n_o,
  input logic [ROW_W-1:0] row_idx_o,
  input logic             frame_start_o,
  input logic             busy_o
);

  localparam int SETTLE_CYC = DAC_SETTLE_US * CLK_PER_US;
  localparam int INT_MIN_C  = MIN_INT_US * CLK_PER_US;
  localparam int INT_MAX_C  = MAX_INT_US * CLK_PER_US;

  int   ld_age;
  int   integ_len;
  int   ref_len;
  logic have_ref;
  logic integ_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_age     <= 0;
      integ_len  <= 0;
      ref_len    <= 0;
      have_ref   <= 1'b0;
      integ_prev <= 1'b0;
    end else begin
      integ_prev <= integ_o;
      if (dac_ld_o) begin
        ld_age <= 1;
      end else if (ld_age < 32'h3fff_ffff) begin
        ld_age <= ld_age + 1;
      end
      if (int_rst_o) begin
        integ_len <= 0;
      end else if (integ_o) begin
        integ_len <= integ_len + 1;
      end
      if (frame_start_o) begin
        have_ref <= 1'b0;
      end else if (integ_prev && !integ_o && !have_ref) begin
        have_ref <= 1'b1;
        ref_len  <= integ_len;
      end
    end
  end

  assert_one_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_rst_o, integ_o, hold_o}));

  assert_phase_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int_rst_o || integ_o || hold_o) |-> busy_o);

  assert_dac_ld_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_ld_o |-> $rose(int_rst_o));

  assert_cnv_first_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv_o |-> $rose(hold_o));

  assert_spi_done_in_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst_o) |-> spi_cs_n_o);

  assert_frame_row0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> (dac_ld_o && row_idx_o == '0));

  assert_dac_settle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_rst_o) |-> (ld_age >= SETTLE_CYC));

  assert_int_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(integ_o) |-> (integ_len >= INT_MIN_C && integ_len <= INT_MAX_C));

  assert_equal_gain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(integ_o) && have_ref) |-> (integ_len == ref_len));

endmodule

bind row_scan_seq row_scan_seq_chk #(
  .CLK_PER_US(CLK_PER_US), .NUM_ROWS(NUM_ROWS), .DAC_SETTLE_US(DAC_SETTLE_US),
  .MIN_INT_US(MIN_INT_US), .MAX_INT_US(MAX_INT_US)
) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .int_rst_o    (int_rst_o),
  .integ_o      (integ_o),
  .hold_o       (hold_o),
  .dac_ld_o     (dac_ld_o),
  .adc_cnv_o    (adc_cnv_o),
  .spi_cs_n_o   (spi_cs_n_o),
  .row_idx_o    (row_idx_o),
  .frame_start_o(frame_start_o),
  .busy_o       (busy_o)
);

// File: tb/test_row_scan_seq.sv
module test_row_scan_seq;

  localparam int CPU    = 2;
  localparam int NR     = 4;
  localparam int RW     = 2;
  localparam int RST_C  = 10 * CPU;
  localparam int HOLD_C = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic [11:0]   int_us_i;
  logic [RW:0]   row_cnt_i;
  logic          int_rst_o, integ_o, hold_o, dac_ld_o, adc_cnv_o;
  logic          spi_cs_n_o, spi_sclk_o, spi_mosi_o;
  logic [RW-1:0] row_idx_o;
  logic          frame_start_o, row_done_o, busy_o;

  always #10 clk = ~clk;

  row_scan_seq #(.CLK_PER_US(CPU), .NUM_ROWS(NR), .HOLD_CYC(HOLD_C)) i_row_scan_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .int_us_i(int_us_i), .row_cnt_i(row_cnt_i),
    .int_rst_o(int_rst_o), .integ_o(integ_o), .hold_o(hold_o), .dac_ld_o(dac_ld_o),
    .adc_cnv_o(adc_cnv_o), .spi_cs_n_o(spi_cs_n_o), .spi_sclk_o(spi_sclk_o),
    .spi_mosi_o(spi_mosi_o), .row_idx_o(row_idx_o), .frame_start_o(frame_start_o),
    .row_done_o(row_done_o), .busy_o(busy_o));

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  bit m_act;
  int m_t, m_ti, m_nr;
  int fs_cnt, rd_cnt;

  function automatic int clamp_us(input int v);
    return (v < 100) ? 100 : ((v > 2000) ? 2000 : v);
  endfunction

  function automatic int clamp_rows(input int v);
    return (v < 1) ? 1 : ((v > NR) ? NR : v);
  endfunction

  task automatic cmp(input string req, input string nm, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, nm, got, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act <= 1'b0;
      m_t   <= 0;
    end else if (m_act) begin
      if (m_t + 1 == m_nr * (RST_C + m_ti + HOLD_C)) m_act <= 1'b0;
      m_t <= m_t + 1;
    end else if (start_i) begin
      m_act <= 1'b1;
      m_t   <= 0;
      m_ti  <= clamp_us(int_us_i) * CPU;
      m_nr  <= clamp_rows(row_cnt_i);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      int per, row, off, k;
      bit e_cs, e_sclk, e_mosi;
      string tr;
      per = RST_C + m_ti + HOLD_C;
      row = m_act ? m_t / per : 0;
      off = m_act ? m_t % per : -1;
      e_cs   = !(m_act && off >= 1 && off <= 2 * RW);
      k      = (off - 1) / 2;
      e_sclk = !e_cs && ((off - 1) % 2 == 1);
      e_mosi = !e_cs && (((row >> (RW - 1 - k)) & 1) == 1);
      tr = rst_n ? "" : "R1 ";
      cmp({tr, "R3"}, "int_rst", int_rst_o, m_act && off < RST_C);
      cmp({tr, "R3"}, "dac_ld", dac_ld_o, m_act && off == 0);
      cmp({tr, "R4"}, "integ", integ_o, m_act && off >= RST_C && off < RST_C + m_ti);
      cmp({tr, "R5"}, "hold", hold_o, m_act && off >= RST_C + m_ti);
      cmp({tr, "R5"}, "adc_cnv", adc_cnv_o, m_act && off == RST_C + m_ti);
      cmp({tr, "R6"}, "row_idx", row_idx_o, row);
      cmp({tr, "R7"}, "spi_cs_n", spi_cs_n_o, e_cs);
      cmp({tr, "R7"}, "spi_sclk", spi_sclk_o, e_sclk);
      cmp({tr, "R7"}, "spi_mosi", spi_mosi_o, e_mosi);
      cmp({tr, "R8"}, "frame_start", frame_start_o, m_act && off == 0 && row == 0);
      cmp({tr, "R8"}, "row_done", row_done_o, m_act && off == per - 1);
      cmp({tr, "R9"}, "busy", busy_o, m_act);
      if (frame_start_o) fs_cnt++;
      if (row_done_o) rd_cnt++;
    end
  end

  task automatic run_frame(input int us, input int rows, input bit poke);
    @(negedge clk);
    int_us_i  = 12'(us);
    row_cnt_i = (RW+1)'(rows);
    start_i   = 1'b1;
    fs_cnt    = 0;
    rd_cnt    = 0;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      // R2 / R4 / R6: mid-frame changes and a second start must not disturb the frame
      repeat (300) @(negedge clk);
      int_us_i  = 12'd100;
      row_cnt_i = (RW+1)'(1);
      start_i   = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    cmp("R8", "frame_start pulses", fs_cnt, 1);
    cmp("R6", "rows scanned", rd_cnt, clamp_rows(rows));
    repeat (5) @(negedge clk);
  endtask

  initial begin
    rst_n     = 1'b0;
    start_i   = 1'b0;
    int_us_i  = 12'd100;
    row_cnt_i = '0;
    repeat (3) @(negedge clk);
    cmp("R1", "busy in reset", busy_o, 0);
    cmp("R1", "cs_n in reset", spi_cs_n_o, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_frame(100, 4, 1'b0);   // minimum integration, all rows
    run_frame(50, 0, 1'b0);    // R4 clamp up, R6 zero rows -> one
    run_frame(4095, 7, 1'b0);  // R4 clamp down, R6 too many rows -> NUM_ROWS
    run_frame(333, 3, 1'b1);   // R2 start while busy ignored
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule